// File: doc/BRIEF.md
# H-Bridge Fault Supervisor and Direction Control

This block sits between a two-bit direction command and the gate drivers of a four-switch H-bridge. It decodes the command into coast, reverse, forward or brake. It watches three protection inputs: a per-cycle overcurrent flag from the current-limit circuit, an over-temperature comparator whose hysteresis lies outside the block, and a supply undervoltage comparator. When any of them is active, it turns all four switches off.

The three causes recover in different ways. Overcurrent must persist for a programmed number of cycles before it trips. Once tripped, it stays latched until software pulses a clear strobe or reset is applied. Over-temperature and undervoltage clear on their own when the comparator releases. A four-bit status word and an active-low fault pin report the state. A zero command puts the bridge to sleep: both legs float and the persistence timer stays idle.

Every output is derived from registers only. A change on any input shows at the outputs after one rising clock edge.

Top module: `hbridge_supervisor`

## Requirements
- R1: The overcurrent cause trips only after `oc_flag` has been high on more than `OC_LIMIT` consecutive rising edges, which means `OC_LIMIT+1` edges. A run of `OC_LIMIT` edges or fewer does not trip. Any low cycle restarts the count from zero.
- R2: While any cause is set, all four enables are 0 and `fault_n` is 0. `fault_status` uses these bit positions: [0] summary, [1] overcurrent, [2] over-temperature, [3] undervoltage. The summary bit is set together with the bit of the cause.
- R3: The overcurrent bit stays set after `oc_flag` drops. It clears only on the edge after a one-cycle `clr_fault` pulse, or on reset. `clr_fault` does not touch bits [2] and [3].
- R4: A clear given while `oc_flag` is still high restarts the persistence count. The cause trips again only after another `OC_LIMIT+1` high edges counted from the clearing edge.
- R5: Bit [2] follows `ot_flag` one edge later and releases by itself when `ot_flag` falls.
- R6: Bit [3] follows `uv_flag` one edge later and releases by itself when `uv_flag` falls. While `uv_flag` is high, the persistence timer is held at zero.
- R7: The command `cmd` is {IN1, IN2} and is registered once. Bit [0] of `hs_en` and `ls_en` is leg OUT1 and bit [1] is leg OUT2; a leg is high when its high-side enable is on, low when its low-side enable is on, and floating when both are off. With no fault, the decode is: 00 makes both legs float; 01 makes OUT1 low and OUT2 high; 10 makes OUT1 high and OUT2 low; 11 makes both legs high. The two enables of one leg are never on together.
- R8: When the registered command is 00, `sleep` is 1 and the bridge is off. While `cmd` is 00, the persistence timer is held at zero, so an overcurrent flag cannot trip.
- R9: `fault_n` returns high and the summary bit clears only when bits [3:1] are all 0.
- R10: After reset, `fault_status` is 0, `fault_n` is 1, `sleep` is 1 and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Direction command {IN1, IN2} |
| oc_flag | input | 1 | Current-limit active this cycle |
| ot_flag | input | 1 | Over-temperature comparator, high = hot |
| uv_flag | input | 1 | Undervoltage comparator, high = supply low |
| clr_fault | input | 1 | One-cycle pulse that clears the latched overcurrent |
| hs_en | output | 2 | High-side enables, [0] OUT1, [1] OUT2 |
| ls_en | output | 2 | Low-side enables, [0] OUT1, [1] OUT2 |
| fault_n | output | 1 | Active-low fault indication |
| fault_status | output | 4 | {undervoltage, over-temperature, overcurrent, summary} |
| sleep | output | 1 | Bridge in sleep (command 00) |

## Verification
Most internal faults reach the ports within one edge. A wrong persistence count moves the overcurrent trip earlier or later by whole cycles. The bench therefore probes the edge just before the expected trip and the edge of the trip itself. A latch that leaks or fails to hold shows as bit [1] changing on the edge after `oc_flag` falls, or after a clear. A timer left running during sleep or undervoltage shows as a trip on the first active cycle, when `OC_LIMIT+1` cycles should be needed. A wrong decode shows at once in the enable pattern for the matching command.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    CMD_COAST = 2'b00,
    CMD_REV   = 2'b01,
    CMD_FWD   = 2'b10,
    CMD_BRAKE = 2'b11
  } hb_cmd_e;

  localparam int unsigned ST_SUM = 0;
  localparam int unsigned ST_OC  = 1;
  localparam int unsigned ST_OT  = 2;
  localparam int unsigned ST_UV  = 3;
  localparam int unsigned ST_W   = 4;
  localparam int unsigned LEGS   = 2;
endpackage

// File: rtl/hb_oc_timer.sv
module hb_oc_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_flag,
  input  logic hold,
  input  logic restart,
  output logic trip
);
  localparam int unsigned CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] TERM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold || restart || !oc_flag) cnt <= '0;
    else if (cnt != TERM)                   cnt <= cnt + 1'b1;
  end

  // trip on the (LIMIT+1)-th consecutive high sample
  assign trip = oc_flag && !hold && !restart && (cnt == TERM);

  // R1: a non-zero count implies the flag was high on the previous edge
  a_r1_count_needs_flag: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> $past(oc_flag));
endmodule

// File: rtl/hb_fault_status.sv
module hb_fault_status
  import hb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            oc_trip,
  input  logic            clr,
  input  logic            ot_flag,
  input  logic            uv_flag,
  output logic [ST_W-1:0] status
);
  logic oc_q, ot_q, uv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oc_q <= 1'b0;
      ot_q <= 1'b0;
      uv_q <= 1'b0;
    end else begin
      ot_q <= ot_flag;
      uv_q <= uv_flag;
      if (clr)          oc_q <= 1'b0;
      else if (oc_trip) oc_q <= 1'b1;
    end
  end

  always_comb begin
    status         = '0;
    status[ST_OC]  = oc_q;
    status[ST_OT]  = ot_q;
    status[ST_UV]  = uv_q;
    status[ST_SUM] = oc_q | ot_q | uv_q;
  end

  // R3: latched overcurrent survives until a clear
  a_r3_oc_latched: assert property (@(posedge clk) disable iff (rst)
    (oc_q && !clr) |=> oc_q);
endmodule

// File: rtl/hb_bridge_decode.sv
module hb_bridge_decode
  import hb_pkg::*;
(
  input  hb_cmd_e          cmd,
  input  logic             kill,
  output logic [LEGS-1:0]  hs,
  output logic [LEGS-1:0]  ls
);
  always_comb begin
    hs = '0;
    ls = '0;
    if (!kill) begin
      unique case (cmd)
        CMD_COAST: begin hs = 2'b00; ls = 2'b00; end
        CMD_REV:   begin hs = 2'b10; ls = 2'b01; end
        CMD_FWD:   begin hs = 2'b01; ls = 2'b10; end
        CMD_BRAKE: begin hs = 2'b11; ls = 2'b00; end
        default:   begin hs = 2'b00; ls = 2'b00; end
      endcase
    end
  end

  // R7: no leg may conduct through both of its switches
  always_comb begin
    a_r7_leg_exclusive: assert ((hs & ls) == '0);
  end
endmodule

// File: rtl/hbridge_supervisor.sv
module hbridge_supervisor
  import hb_pkg::*;
#(
  parameter int unsigned OC_LIMIT = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cmd,
  input  logic       oc_flag,
  input  logic       ot_flag,
  input  logic       uv_flag,
  input  logic       clr_fault,
  output logic [1:0] hs_en,
  output logic [1:0] ls_en,
  output logic       fault_n,
  output logic [3:0] fault_status,
  output logic       sleep
);
  hb_cmd_e cmd_q;
  logic    oc_trip;
  logic    timer_hold;

  always_ff @(posedge clk) begin
    if (rst) cmd_q <= CMD_COAST;
    else     cmd_q <= hb_cmd_e'(cmd);
  end

  // sleep and undervoltage idle the internal timer
  assign timer_hold = uv_flag || (cmd == 2'b00);

  hb_oc_timer #(.LIMIT(OC_LIMIT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .oc_flag (oc_flag),
    .hold    (timer_hold),
    .restart (clr_fault),
    .trip    (oc_trip)
  );

  hb_fault_status u_status (
    .clk     (clk),
    .rst     (rst),
    .oc_trip (oc_trip),
    .clr     (clr_fault),
    .ot_flag (ot_flag),
    .uv_flag (uv_flag),
    .status  (fault_status)
  );

  hb_bridge_decode u_decode (
    .cmd  (cmd_q),
    .kill (fault_status[ST_SUM]),
    .hs   (hs_en),
    .ls   (ls_en)
  );

  assign fault_n = ~fault_status[ST_SUM];
  assign sleep   = (cmd_q == CMD_COAST);

  // R2: a reported fault leaves every switch off
  a_r2_fault_kills_bridge: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> (hs_en == 2'b00 && ls_en == 2'b00));
  // R8: sleep leaves every switch off
  a_r8_sleep_off: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (hs_en == 2'b00 && ls_en == 2'b00));
  // R3: a clear pulse removes the overcurrent bit on the next edge
  a_r3_clear_drops_oc: assert property (@(posedge clk) disable iff (rst)
    clr_fault |=> !fault_status[ST_OC]);
  // R5: over-temperature reported one edge later
  a_r5_ot_reported: assert property (@(posedge clk) disable iff (rst)
    ot_flag |=> fault_status[ST_OT]);
  // R6: undervoltage reported one edge later
  a_r6_uv_reported: assert property (@(posedge clk) disable iff (rst)
    uv_flag |=> fault_status[ST_UV]);
  // R1: overcurrent can only appear after the flag was high
  a_r1_rise_needs_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_status[ST_OC]) |-> $past(oc_flag));
endmodule

// File: tb/hbridge_supervisor_tb.sv
`timescale 1ns/1ps
module hbridge_supervisor_tb;
  localparam int unsigned LIM = 4;
  localparam int NV = 8;
  // {cmd[13:12], ot[11], uv[10], hs[9:8], ls[7:6], status[5:2], fault_n[1], sleep[0]}
  localparam logic [13:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b0, 2'b00, 2'b00, 4'b0000, 1'b1, 1'b1},
    {2'b01, 1'b0, 1'b0, 2'b10, 2'b01, 4'b0000, 1'b1, 1'b0},
    {2'b10, 1'b0, 1'b0, 2'b01, 2'b10, 4'b0000, 1'b1, 1'b0},
    {2'b11, 1'b0, 1'b0, 2'b11, 2'b00, 4'b0000, 1'b1, 1'b0},
    {2'b10, 1'b1, 1'b0, 2'b00, 2'b00, 4'b0101, 1'b0, 1'b0},
    {2'b01, 1'b0, 1'b1, 2'b00, 2'b00, 4'b1001, 1'b0, 1'b0},
    {2'b11, 1'b1, 1'b1, 2'b00, 2'b00, 4'b1101, 1'b0, 1'b0},
    {2'b11, 1'b0, 1'b0, 2'b11, 2'b00, 4'b0000, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cmd = 2'b00;
  logic oc_flag = 1'b0, ot_flag = 1'b0, uv_flag = 1'b0, clr_fault = 1'b0;
  logic [1:0] hs_en, ls_en;
  logic fault_n, sleep;
  logic [3:0] fault_status;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hbridge_supervisor #(.OC_LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst), .cmd(cmd), .oc_flag(oc_flag), .ot_flag(ot_flag),
    .uv_flag(uv_flag), .clr_fault(clr_fault), .hs_en(hs_en), .ls_en(ls_en),
    .fault_n(fault_n), .fault_status(fault_status), .sleep(sleep)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // advance n rising edges, then settle 1 ns past the last edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    // R10: reset state
    check("R10 status", fault_status, 4'h0);
    check("R10 fault_n", fault_n, 1);
    check("R10 sleep", sleep, 1);
    check("R10 enables", {hs_en, ls_en}, 4'h0);

    // vector table: R7 decode, R2/R5/R6/R9 fault reporting
    for (int i = 0; i < NV; i++) begin
      cmd = VEC[i][13:12]; ot_flag = VEC[i][11]; uv_flag = VEC[i][10];
      step(1);
      check($sformatf("R7 hs vec%0d", i), hs_en, VEC[i][9:8]);
      check($sformatf("R7 ls vec%0d", i), ls_en, VEC[i][7:6]);
      check($sformatf("R2 status vec%0d", i), fault_status, VEC[i][5:2]);
      check($sformatf("R9 fault_n vec%0d", i), fault_n, VEC[i][1]);
      check($sformatf("R8 sleep vec%0d", i), sleep, VEC[i][0]);
    end

    // R1: LIM high edges do not trip, drop resets the count
    cmd = 2'b10; ot_flag = 0; uv_flag = 0;
    step(1);
    oc_flag = 1; step(LIM);
    check("R1 short burst", fault_status[1], 0);
    oc_flag = 0; step(1);
    oc_flag = 1; step(LIM);
    check("R1 count restarted", fault_status[1], 0);
    step(1);
    check("R1 trip at LIM+1", fault_status, 4'b0011);
    check("R2 bridge off", {hs_en, ls_en, fault_n}, 5'b0);

    // R3: latched after flag drops; clear leaves ot alone
    oc_flag = 0; ot_flag = 1; step(3);
    check("R3 latched", fault_status, 4'b0111);
    clr_fault = 1; step(1); clr_fault = 0;
    check("R3 clear keeps ot", fault_status, 4'b0101);
    ot_flag = 0; step(1);
    check("R5 ot self release", fault_status, 4'b0000);
    check("R9 fault_n high", fault_n, 1);

    // R4: clear while flag still high restarts the count
    oc_flag = 1; step(LIM + 1);
    check("R4 pre-trip", fault_status[1], 1);
    clr_fault = 1; step(1); clr_fault = 0;
    check("R4 cleared", fault_status[1], 0);
    step(LIM);
    check("R4 no early retrip", fault_status[1], 0);
    step(1);
    check("R4 retrip", fault_status[1], 1);
    oc_flag = 0; clr_fault = 1; step(1); clr_fault = 0;
    check("R3 cleared idle", fault_status, 4'b0000);

    // R8: sleep holds the timer
    cmd = 2'b00; oc_flag = 1; step(LIM + 5);
    check("R8 no trip asleep", fault_status[1], 0);
    check("R8 sleep flag", sleep, 1);
    cmd = 2'b10; step(LIM);
    check("R8 timer restarted on wake", fault_status[1], 0);
    step(1);
    check("R8 trip after wake", fault_status[1], 1);
    oc_flag = 0; clr_fault = 1; step(1); clr_fault = 0;

    // R6: undervoltage holds the timer
    uv_flag = 1; oc_flag = 1; step(LIM + 5);
    check("R6 uv only", fault_status, 4'b1001);
    uv_flag = 0; step(LIM);
    check("R6 uv released, no trip", fault_status, 4'b0000);
    check("R7 fwd restored", {hs_en, ls_en}, 4'b0110);
    step(1);
    check("R6 trip after uv", fault_status[1], 1);
    oc_flag = 0;

    // R10: reset clears the latched cause
    rst = 1; step(1); rst = 0;
    check("R10 reset clears oc", fault_status, 4'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule